// File: doc/BRIEF.md
# Byte-Parallel Self-Synchronizing Scrambler

This block scrambles a byte stream, one 8-bit byte per clock. It keeps a 7-stage history register and uses the recurrence `y = d ^ h4 ^ h7`. Here `hK` is the bit that entered the history K steps earlier. Bit 0 of each byte is taken first and bit 7 last. The eight serial steps are unrolled into one combinational network, so the scrambled byte and the next history value are both ready within one cycle. The result is registered, so it appears one cycle after the input.

A mode input chooses what enters the history at each step:
- In scramble mode, the produced bit enters the history.
- In descramble mode, the received bit enters the history.

In descramble mode the history fills from the line data alone. It therefore matches a scrambler's history after seven received bits, whatever the starting value. A synchronous reset loads a seed taken from a port; the usual seed is all ones.

A two-state output machine drives the valid strobe:
- `ST_IDLE`: no byte was taken on the previous edge, and `out_vld` is low. This is the state after reset.
- `ST_EMIT`: a byte was taken on the previous edge, and `out_vld` is high.
- Transitions: any state goes to `ST_EMIT` on an edge where `in_vld` is high, and to `ST_IDLE` on an edge where `in_vld` is low.

Top module: `byte_scrambler`

## Requirements
- R1: While `rst` is high on a clock edge, the history register loads `seed` (bit k = the history bit of delay k+1), `out_vld` goes low and `dout` goes to 0x00; the state machine enters `ST_IDLE`.
- R2: Each serial step computes `y = d ^ h4 ^ h7`, taking byte bit 0 first up to bit 7 last; `dout` bit i holds the result for input bit i. From seed 0x7F in scramble mode, input 0x00 yields 0x70.
- R3: In scramble mode, each produced bit `y` is shifted into the history as the new delay-1 bit, and every older bit moves one delay further.
- R4: In descramble mode, each received bit `d` is shifted into the history in place of `y`.
- R5: A byte presented with `in_vld` high is fully processed (eight serial steps) in that cycle; its result is on `dout` after the next rising edge.
- R6: On an edge with `in_vld` low, the history register and `dout` keep their values.
- R7: Scrambling a stream and then descrambling it, from any descrambler seed, returns the original data: bit 7 of the first byte and every bit of all later bytes.
- R8: `out_vld` is high exactly in the cycle after an edge where `in_vld` was high (`ST_EMIT`), and low otherwise (`ST_IDLE`).
- R9: `descr` is sampled per byte, so the mode may change between consecutive bytes without disturbing the history carried across.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed | input | 7 | History value loaded during reset |
| descr | input | 1 | 0 = scramble, 1 = descramble |
| in_vld | input | 1 | Input byte strobe |
| din | input | 8 | Input byte, bit 0 processed first |
| out_vld | output | 1 | Output byte strobe |
| dout | output | 8 | Processed byte, registered |

## Verification
The following are checked on every cycle:
- After each accepted byte, the history equals the last seven bits that entered it: the output bits in scramble mode, or the input bits in descramble mode.
- The history and output hold during idle cycles.
- The valid strobe follows the input strobe by one cycle.
- Reset loads the seed.

Some behaviours can only be shown by the bench's scenarios, which compare against a bit-serial model: the exact XOR taps and bit order, seed-dependent output, round-trip recovery with the descrambler's self-locking, and mid-stream mode changes.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_st_t;

    typedef enum logic [0:0] {
        MODE_SCRAMBLE   = 1'b0,
        MODE_DESCRAMBLE = 1'b1
    } scr_mode_t;
endpackage

// File: rtl/scr_unroll.sv
module scr_unroll #(
    parameter int DATA_W = 8,
    parameter int HIST_W = 7,
    parameter int TAP_A  = 4,
    parameter int TAP_B  = 7
) (
    input  logic [HIST_W-1:0] hist_i,
    input  logic [DATA_W-1:0] d_i,
    input  scr_pkg::scr_mode_t mode_i,
    output logic [DATA_W-1:0] y_o,
    output logic [HIST_W-1:0] hist_o
);
    // chain[i] is the history before serial step i; chain[DATA_W] is the result
    logic [DATA_W:0][HIST_W-1:0] chain;
    assign chain[0] = hist_i;

    for (genvar i = 0; i < DATA_W; i++) begin : g_step
        logic y_bit, fb_bit;
        assign y_bit  = d_i[i] ^ chain[i][TAP_A-1] ^ chain[i][TAP_B-1];
        assign fb_bit = (mode_i == scr_pkg::MODE_DESCRAMBLE) ? d_i[i] : y_bit;
        assign y_o[i] = y_bit;
        assign chain[i+1] = {chain[i][HIST_W-2:0], fb_bit};
    end

    assign hist_o = chain[DATA_W];
endmodule

// File: rtl/scr_state.sv
module scr_state #(
    parameter int HIST_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] seed_i,
    input  logic              upd_i,
    input  logic [HIST_W-1:0] nxt_i,
    output logic [HIST_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= seed_i;
        else if (upd_i) q_o <= nxt_i;
    end

    // R1: reset loads the seed
    p_seed_load_r1: assert property (@(posedge clk) rst |=> (q_o == $past(seed_i)));
    // R6: history frozen when no byte is taken
    p_hist_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(q_o));
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld_i,
    input  logic [DATA_W-1:0] y_i,
    output logic              out_vld_o,
    output logic [DATA_W-1:0] dout_o
);
    import scr_pkg::*;

    emit_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = in_vld_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_d = in_vld_i ? ST_EMIT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           dout_o <= '0;
        else if (in_vld_i) dout_o <= y_i;
    end

    assign out_vld_o = (st_q == ST_EMIT);

    // R8: strobe follows the input strobe by one cycle
    p_vld_rise_r8: assert property (@(posedge clk) disable iff (rst)
        in_vld_i |=> out_vld_o);
    p_vld_low_r8: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> !out_vld_o);
    // R6: output byte held when idle
    p_dout_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> $stable(dout_o));
    // R1: reset clears the strobe
    p_rst_idle_r1: assert property (@(posedge clk) rst |=> !out_vld_o);
endmodule

// File: rtl/byte_scrambler.sv
module byte_scrambler #(
    parameter int DATA_W = 8,
    parameter int HIST_W = 7,
    parameter int TAP_A  = 4,
    parameter int TAP_B  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] seed,
    input  logic              descr,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] din,
    output logic              out_vld,
    output logic [DATA_W-1:0] dout
);
    import scr_pkg::*;

    logic [HIST_W-1:0] hist_q, hist_nxt;
    logic [DATA_W-1:0] y_comb;
    scr_mode_t         mode;

    assign mode = scr_mode_t'(descr);

    scr_unroll #(
        .DATA_W(DATA_W), .HIST_W(HIST_W), .TAP_A(TAP_A), .TAP_B(TAP_B)
    ) u_unroll (
        .hist_i(hist_q), .d_i(din), .mode_i(mode),
        .y_o(y_comb), .hist_o(hist_nxt)
    );

    scr_state #(.HIST_W(HIST_W)) u_state (
        .clk(clk), .rst(rst), .seed_i(seed),
        .upd_i(in_vld), .nxt_i(hist_nxt), .q_o(hist_q)
    );

    scr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst), .in_vld_i(in_vld), .y_i(y_comb),
        .out_vld_o(out_vld), .dout_o(dout)
    );

    // Last HIST_W bits of a byte, newest (bit DATA_W-1) at history index 0
    function automatic logic [HIST_W-1:0] tail_rev(input logic [DATA_W-1:0] v);
        logic [HIST_W-1:0] r;
        for (int k = 0; k < HIST_W; k++) r[k] = v[DATA_W-1-k];
        return r;
    endfunction

    // R3: after scrambling a byte the history holds its last output bits
    p_hist_tracks_out_r3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !descr) |=> (hist_q == tail_rev(dout)));
    // R4: after descrambling a byte the history holds its last input bits
    p_hist_tracks_in_r4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && descr) |=> (hist_q == tail_rev($past(din))));
endmodule

// File: tb/sim_byte_scrambler.sv
module sim_byte_scrambler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] seed = 7'h7F;
    logic       descr = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] din = 8'h00;
    logic       out_vld;
    logic [7:0] dout;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    byte_scrambler u0 (
        .clk(clk), .rst(rst), .seed(seed), .descr(descr),
        .in_vld(in_vld), .din(din), .out_vld(out_vld), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bit-serial model: h[k] is the bit of delay k+1
    task automatic ref_byte(inout logic [6:0] h, input logic [7:0] d,
                            input bit dsc, output logic [7:0] y);
        for (int i = 0; i < 8; i++) begin
            logic b;
            b = d[i] ^ h[3] ^ h[6];
            y[i] = b;
            h = {h[5:0], dsc ? d[i] : b};
        end
    endtask

    task automatic do_reset(input logic [6:0] s);
        @(negedge clk);
        rst = 1'b1; seed = s; in_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // called at a negedge; returns at the next negedge with outputs sampled
    task automatic send(input bit dsc, input logic [7:0] d, output logic [7:0] y, output logic v);
        descr = dsc; din = d; in_vld = 1'b1;
        @(negedge clk);
        y = dout; v = out_vld;
        in_vld = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(7'h7F);
        check(out_vld == 1'b0, "R1 out_vld after reset", out_vld, 0);
        check(dout == 8'h00, "R1 dout after reset", dout, 0);
    endtask

    task automatic t_known_vector;
        logic [7:0] y; logic v;
        do_reset(7'h7F);
        send(1'b0, 8'h00, y, v);
        check(y == 8'h70, "R2 R3 known vector", y, 8'h70);
        check(v == 1'b1, "R5 R8 latency one", v, 1);
    endtask

    task automatic t_seed;
        logic [6:0] h; logic [7:0] y, e; logic v;
        do_reset(7'h55);
        h = 7'h55;
        ref_byte(h, 8'hA3, 1'b0, e);
        send(1'b0, 8'hA3, y, v);
        check(y == e, "R1 seed used", y, e);
    endtask

    task automatic t_stream(input bit dsc, input string req);
        logic [6:0] h; logic [7:0] y, e, d; logic v;
        do_reset(7'h7F);
        h = 7'h7F;
        for (int n = 0; n < 40; n++) begin
            d = 8'($urandom);
            ref_byte(h, d, dsc, e);
            descr = dsc; din = d; in_vld = 1'b1;
            @(negedge clk);
            check(dout == e && out_vld, req, dout, e);
        end
        in_vld = 1'b0;
    endtask

    task automatic t_gaps;
        logic [6:0] h; logic [7:0] y, e, held; logic v;
        do_reset(7'h3C);
        h = 7'h3C;
        ref_byte(h, 8'h5A, 1'b0, e);
        send(1'b0, 8'h5A, y, v);
        held = y;
        check(y == e, "R5 gap first byte", y, e);
        for (int n = 0; n < 3; n++) begin
            din = 8'hFF; descr = 1'b0;
            @(negedge clk);
            check(out_vld == 1'b0, "R8 out_vld low in gap", out_vld, 0);
            check(dout == held, "R6 dout held in gap", dout, held);
        end
        ref_byte(h, 8'hC3, 1'b0, e);
        send(1'b0, 8'hC3, y, v);
        check(y == e, "R6 history held across gap", y, e);
    endtask

    task automatic t_roundtrip;
        logic [7:0] src [20];
        logic [7:0] sc  [20];
        logic [7:0] y; logic v;
        do_reset(7'h7F);
        for (int n = 0; n < 20; n++) begin
            src[n] = 8'($urandom);
            send(1'b0, src[n], sc[n], v);
            @(negedge clk);
        end
        do_reset(7'h2A);
        for (int n = 0; n < 20; n++) begin
            send(1'b1, sc[n], y, v);
            if (n == 0)
                check(y[7] == src[0][7], "R7 lock bit 7 of first byte", y[7], src[0][7]);
            else
                check(y == src[n], "R7 round trip", y, src[n]);
        end
    endtask

    task automatic t_mode_switch;
        logic [6:0] h; logic [7:0] e, d;
        do_reset(7'h11);
        h = 7'h11;
        for (int n = 0; n < 16; n++) begin
            bit m;
            m = n[0] ^ n[2];
            d = 8'($urandom);
            ref_byte(h, d, m, e);
            descr = m; din = d; in_vld = 1'b1;
            @(negedge clk);
            check(dout == e, "R9 mode per byte", dout, e);
        end
        in_vld = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_known_vector();
        t_seed();
        t_stream(1'b0, "R3 R5 scramble stream");
        t_stream(1'b1, "R4 R5 descramble stream");
        t_gaps();
        t_roundtrip();
        t_mode_switch();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule